// File: doc/BRIEF.md
# Pulse-Width Audio Output Stage

This block converts a stream of unsigned 16-bit audio samples into one pulse-width-modulated bit. The bit drives an external low-pass filter and amplifier, which recover the analog level from the duty cycle. A free-running period counter divides the output into frames of 512 clocks. From a clock of about 21.477 MHz this gives a frame rate near 42 kHz.

At the first clock of each frame, the sample input is captured into a holding register. That value stays fixed for the whole frame, whatever the producer does to the input in the meantime. In each clock the counter is scaled up to sample width by appending zero bits below it, then compared against the held value. The output is high while the scaled count is below the held sample. It is also forced high on count zero, so even a silent sample gives one high clock per frame. The output bit is registered.

Top module: `pwm_audio_dac`

## Requirements
- R1: The period counter advances by one on every clock edge outside reset and wraps from 511 to 0, so one output frame lasts exactly 512 clocks.
- R2: The sample input is captured only at the edge where the counter is 0. Any change to the input at other times has no effect on the frame in progress, and only the value present at the next count-zero edge is used for the following frame.
- R3: For counter value c in 1..511, the output for that slot is 1 exactly when c·128 (c with seven zero bits appended, read as a 16-bit unsigned number) is less than the held sample. The high time of a frame is therefore 1 plus the number of such c that meet this condition.
- R4: The slot for counter value 0 is always high. A held sample of 0 gives exactly one high clock per frame.
- R5: A held sample of 0xFFFF gives an output that is high for all 512 clocks of the frame.
- R6: The output is registered. The slot for counter value c appears on the output in the clock after the edge at which the counter held c, and the high clocks of each frame form one contiguous run that starts at the frame's first slot.
- R7: A synchronous active-high reset clears the counter, the held sample and the output to 0. The first edge after reset is released is a count-zero edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Design clock, about 21.477 MHz |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 16 | Unsigned audio sample; captured at the start of each frame |
| pwm_o | output | 1 | Registered pulse-width-modulated output bit |

## Verification
The hardest case to reach from the ports is a sample change that lands mid-frame, or just before the frame boundary. The output must ignore the first and honour the second, yet nothing at the ports shows where a frame begins. The stimulus aligns itself to the frame by releasing reset, because the first edge after release is known to be count zero. It then counts clocks from there. While measuring the first frame it moves the input twice: once in the middle of the frame and once in the last slot before the boundary. The high-time and shape of both frames are then compared with values worked out from the comparison rule.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

  // Default geometry of the output stage.
  localparam int unsigned PWM_SAMPLE_W = 16;
  localparam int unsigned PWM_COUNT_W  = 9;

endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frame_start_o
);

  logic [CNT_W-1:0] cnt_q;

  // Free-running counter; wraps naturally at 2**CNT_W.
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o         = cnt_q;
  assign frame_start_o = (cnt_q == '0);

  // R1: each clock the count moves on by exactly one, wrapping at the top
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R7: reset leaves the counter at zero
  assert_cnt_reset_R7: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_sample_hold.sv
module pwm_sample_hold #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] held_o
);

  logic [SAMPLE_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)         held_q <= '0;
    else if (load_i) held_q <= sample_i;
  end

  assign held_o = held_q;

  // R2: outside the frame start the held sample never moves
  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(held_q));

  // R2: at the frame start the input is taken as it stands
  assert_hold_load_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (held_q == $past(sample_i)));

endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CNT_W    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [SAMPLE_W-1:0] held_i,
  output logic                pwm_o
);

  localparam int unsigned SHIFT = SAMPLE_W - CNT_W;

  // Count scaled up to sample width by zero bits below it.
  logic [SAMPLE_W-1:0] scaled_cnt;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign scaled_cnt = cnt_i;
    end else begin : g_shift
      assign scaled_cnt = {cnt_i, {SHIFT{1'b0}}};
    end
  endgenerate

  function automatic logic slot_high(input logic [CNT_W-1:0] c,
                                     input logic [SAMPLE_W-1:0] s,
                                     input logic [SAMPLE_W-1:0] h);
    return (c == '0) || (s < h);
  endfunction

  logic slot_hit;
  logic pwm_q;

  assign slot_hit = slot_high(cnt_i, scaled_cnt, held_i);

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= slot_hit;
  end

  assign pwm_o = pwm_q;

  // R4: count zero always gives a high slot
  assert_zero_slot_high_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_i == '0) |=> pwm_q);

  // R5: full-scale held value keeps the output high
  assert_full_scale_R5: assert property (@(posedge clk) disable iff (rst)
    (held_i == {SAMPLE_W{1'b1}}) |=> pwm_q);

  // R4: silent held value is low outside count zero
  assert_silent_low_R4: assert property (@(posedge clk) disable iff (rst)
    ((held_i == '0) && (cnt_i != '0)) |=> !pwm_q);

  // R6: within a frame the output can only fall, never rise again
  assert_single_run_R6: assert property (@(posedge clk) disable iff (rst)
    ((cnt_i != '0) && !pwm_q) |=> !pwm_q);

  // R7: reset clears the output
  assert_out_reset_R7: assert property (@(posedge clk)
    rst |=> !pwm_q);

endmodule

// File: rtl/pwm_audio_dac.sv
module pwm_audio_dac
  import pwm_dac_pkg::*;
#(
  parameter int unsigned SAMPLE_W = PWM_SAMPLE_W,
  parameter int unsigned CNT_W    = PWM_COUNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                pwm_o
);

  logic [CNT_W-1:0]    cnt;
  logic                frame_start;
  logic [SAMPLE_W-1:0] held;

  pwm_period_counter #(.CNT_W(CNT_W)) u_counter (
    .clk           (clk),
    .rst           (rst),
    .cnt_o         (cnt),
    .frame_start_o (frame_start)
  );

  pwm_sample_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load_i   (frame_start),
    .sample_i (sample_i),
    .held_o   (held)
  );

  pwm_compare_out #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .cnt_i  (cnt),
    .held_i (held),
    .pwm_o  (pwm_o)
  );

endmodule

// File: tb/pwm_audio_dac_tb.sv
module pwm_audio_dac_tb;

  localparam int FRAME = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sample = 16'h0000;
  logic        pwm;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_audio_dac u_dut (
    .clk      (clk),
    .rst      (rst),
    .sample_i (sample),
    .pwm_o    (pwm)
  );

  // Expected slot value: slot 0 always high, else c*128 below the sample.
  function automatic bit exp_slot(input int c, input int unsigned h);
    if (c == 0) return 1'b1;
    return (c * 128) < h;
  endfunction

  function automatic int exp_high(input int unsigned h);
    int n = 0;
    for (int c = 0; c < FRAME; c++) if (exp_slot(c, h)) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Reset with a sample already present; release at a falling edge.
  task automatic do_reset(input logic [15:0] s);
    @(negedge clk);
    rst = 1'b1;
    sample = s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Observe one frame (512 falling edges) and compare with expectations.
  // Optional mid-frame and last-slot input changes.
  task automatic measure(input int unsigned h, input string req,
                         input bit chg, input logic [15:0] mid_s,
                         input logic [15:0] end_s);
    int hi = 0;
    int bad_slot = -1;
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      if (pwm) hi++;
      if (pwm !== exp_slot(i, h) && bad_slot < 0) bad_slot = i;
      if (chg && i == 200) sample = mid_s;
      if (chg && i == FRAME - 1) sample = end_s;
    end
    check(hi == exp_high(h), req, $sformatf("high time for 0x%04h", h),
          hi, exp_high(h));
    check(bad_slot < 0, "R6", $sformatf("slot shape for 0x%04h (first bad slot)", h),
          bad_slot, -1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    sample = 16'hFFFF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(pwm == 1'b0, "R7", "output during reset", pwm, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pwm == 1'b1, "R7", "first slot after release", pwm, 1);
  endtask

  task automatic t_level(input logic [15:0] s, input string req);
    do_reset(s);
    measure(s, req, 1'b0, 16'h0, 16'h0);
  endtask

  // Two frames back to back: checks the wrap (R1) and a fresh latch.
  task automatic t_wrap;
    do_reset(16'h4000);
    measure(16'h4000, "R1", 1'b1, 16'h4000, 16'h0C00);
    measure(16'h0C00, "R1", 1'b0, 16'h0, 16'h0);
  endtask

  // Mid-frame change is ignored; change just before the boundary is used.
  task automatic t_midframe;
    do_reset(16'h2000);
    measure(16'h2000, "R2", 1'b1, 16'hF000, 16'h0180);
    measure(16'h0180, "R2", 1'b0, 16'h0, 16'h0);
  endtask

  initial begin
    t_reset();
    t_level(16'h0000, "R4");
    t_level(16'h0001, "R3");
    t_level(16'h0080, "R3");
    t_level(16'h0081, "R3");
    t_level(16'h1234, "R3");
    t_level(16'h8000, "R3");
    t_level(16'hFF80, "R3");
    t_level(16'hFF81, "R5");
    t_level(16'hFFFF, "R5");
    t_wrap();
    t_midframe();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule